// File: doc/BRIEF.md
# SCSI Controller Register File and Command Decoder

This block is the byte-wide host register set of a simple SCSI bus controller. A host selects one of sixteen byte registers with a 4-bit index (the byte address bits 5:2) and reads or writes it in single-cycle accesses. Behind the index sit a 16-bit transfer count, a 16-byte data FIFO, a command register, status, interrupt and sequence-step registers, and a set of configuration registers. Some reads have side effects: popping the FIFO and acknowledging the interrupt.

Writing the command register decodes the 7-bit opcode. Bit 7 separately selects DMA mode. FIFO flush, chip reset and bus reset are carried out inside the block. Transfer, selection, completion and message-accept opcodes are handed to an external bus sequencer as a one-cycle request that carries an operation code and the transfer length. The sequencer reports back with a one-cycle strobe that loads the status, interrupt and step registers and raises the level interrupt line.

Top module: `scsi_ctrl_regs`

## Requirements
- R1: An access with `bus_sel` high targets the register named by `bus_addr`. `bus_wr` high means a write, low means a read. Every side effect takes place at the clock edge that ends the access.
- R2: A write to index 2 appends the byte to a 16-deep FIFO. A read of index 2 returns the oldest byte and removes it. Index 7 reads the FIFO occupancy. A write while the FIFO holds 16 bytes is dropped.
- R3: A read of index 2 while the FIFO is empty returns the byte most recently removed and changes nothing.
- R4: Indices 0, 1, 8 and 12 to 15 store the full written byte. Index 11 stores only the bits under mask 0x15. Writes to indices 4, 5, 6, 7, 9 and 10 change nothing, and indices 9 and 10 read as zero.
- R5: Index 3 reads back the last command byte written. Bit 7 of that byte drives `dma_mode`, whatever the opcode.
- R6: A `seq_done` strobe loads status (index 4), interrupt (index 5) and step (index 6) and raises `irq`. A read of index 5 returns the interrupt code, then clears every status bit except 0x10 and drops `irq`.
- R7: Opcode 0x01 (flush) sets the interrupt code to 0x08, clears the step register, empties the FIFO and leaves `irq` unchanged.
- R8: Opcode 0x03 (bus reset) sets the interrupt code to 0x80. It raises `irq` only when bit 6 of index 8 is clear.
- R9: Opcode 0x02 (chip reset) and the reset input clear every register, the FIFO, `irq` and `dma_mode`, and set index 14 to 0x04.
- R10: Opcodes 0x10, 0x42, 0x43, 0x11 and 0x12 pulse `seq_go` for exactly the cycle after the write. In that cycle `seq_op` is 1, 2, 3, 4 or 5 respectively and `seq_len` is {index 1, index 0}.
- R11: A transfer count of zero is presented on `seq_len` as 65536.
- R12: Opcode 0x00 and every opcode not listed above raise no interrupt and no request, and change no register other than index 3 and `dma_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register index (byte address bits 5:2) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| seq_done | input | 1 | Sequencer completion strobe |
| seq_status | input | 8 | Status value loaded on `seq_done` |
| seq_intr | input | 8 | Interrupt code loaded on `seq_done` |
| seq_step | input | 8 | Step value loaded on `seq_done` |
| seq_go | output | 1 | One-cycle request to the sequencer |
| seq_op | output | 3 | Requested operation code |
| seq_len | output | 17 | Transfer length, 1 to 65536 |
| dma_mode | output | 1 | DMA mode selected by the last command |
| irq | output | 1 | Level interrupt request |

## Verification
A corrupted FIFO pointer or count appears on the very next read of index 2 or index 7, as a wrong byte or a wrong occupancy. Because occupancy is readable, an overflow is caught without draining the FIFO. A status or interrupt register that is cleared or loaded wrongly shows on the following read of index 4 or 5. An `irq` that is set or cleared wrongly is visible in the cycle right after the command write or the acknowledging read. A bad opcode decode appears on `seq_go`/`seq_op` one cycle after the command write.

// File: rtl/scsi_regs_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the SCSI controller register file.
// Assumes 8-bit host data and a 16-entry register index.
package scsi_regs_pkg;
    localparam int DATA_W = 8;
    localparam int IDX_W  = 4;
    localparam int LEN_W  = 2 * DATA_W + 1;

    // Register indices whose meaning the logic depends on
    localparam logic [IDX_W-1:0] RI_CNT_LO = 4'd0;
    localparam logic [IDX_W-1:0] RI_CNT_HI = 4'd1;
    localparam logic [IDX_W-1:0] RI_FIFO   = 4'd2;
    localparam logic [IDX_W-1:0] RI_CMD    = 4'd3;
    localparam logic [IDX_W-1:0] RI_STAT   = 4'd4;
    localparam logic [IDX_W-1:0] RI_INTR   = 4'd5;
    localparam logic [IDX_W-1:0] RI_STEP   = 4'd6;
    localparam logic [IDX_W-1:0] RI_LEVEL  = 4'd7;
    localparam logic [IDX_W-1:0] RI_CFG_A  = 4'd8;
    localparam logic [IDX_W-1:0] RI_CFG_B  = 4'd11;

    localparam logic [DATA_W-1:0] INTR_FUNC_DONE = 8'h08;
    localparam logic [DATA_W-1:0] INTR_BUS_RESET = 8'h80;
    localparam logic [DATA_W-1:0] STAT_KEEP_MASK = 8'h10;
    localparam logic [DATA_W-1:0] CFG_B_MASK     = 8'h15;
    localparam logic [DATA_W-1:0] ID_VALUE       = 8'h04;
    localparam int               ID_SLOT         = 2;   // index 12 + 2 = 14
    localparam int               IRQ_MASK_BIT    = 6;

    typedef enum logic [2:0] {
        SEQ_NONE     = 3'd0,
        SEQ_XFER     = 3'd1,
        SEQ_SEL      = 3'd2,
        SEQ_SEL_STOP = 3'd3,
        SEQ_CMPL     = 3'd4,
        SEQ_MSGACC   = 3'd5
    } seq_op_t;

    typedef struct packed {
        logic    flush;
        logic    chip_rst;
        logic    bus_rst;
        logic    seq_go;
        seq_op_t op;
    } cmd_act_t;
endpackage

// File: rtl/scsi_cmd_decode.sv
`timescale 1ns/1ps
// Command opcode decoder: maps the 7-bit opcode to internal actions.
// Purely combinational; unknown opcodes decode to no action.
module scsi_cmd_decode
    import scsi_regs_pkg::*;
(
    input  logic [6:0] opcode,
    output cmd_act_t   act
);
    // Opcode to action table
    always_comb begin
        act    = '0;
        act.op = SEQ_NONE;
        case (opcode)
            7'h01: act.flush    = 1'b1;
            7'h02: act.chip_rst = 1'b1;
            7'h03: act.bus_rst  = 1'b1;
            7'h10: begin act.seq_go = 1'b1; act.op = SEQ_XFER;     end
            7'h42: begin act.seq_go = 1'b1; act.op = SEQ_SEL;      end
            7'h43: begin act.seq_go = 1'b1; act.op = SEQ_SEL_STOP; end
            7'h11: begin act.seq_go = 1'b1; act.op = SEQ_CMPL;     end
            7'h12: begin act.seq_go = 1'b1; act.op = SEQ_MSGACC;   end
            default: ;
        endcase
    end
endmodule

// File: rtl/scsi_byte_fifo.sv
`timescale 1ns/1ps
// Byte FIFO with synchronous clear. Full pushes and empty pops are ignored.
// Pointers return to zero whenever the FIFO drains.
module scsi_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr,
    input  logic                       push,
    input  logic                       pop,
    input  logic [W-1:0]               wdata,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             push_ok, pop_ok, full;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    // Pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (pop_ok && !push_ok && count == CNT_W'(1)) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end
endmodule

// File: rtl/scsi_ctrl_regs.sv
`timescale 1ns/1ps
// Host register file of a SCSI bus controller.
// Assumes single-cycle accesses and one access per cycle. Reads of the
// FIFO and interrupt registers have side effects at the closing edge.
// Bus phases are run by an external sequencer driven through seq_go.
module scsi_ctrl_regs
    import scsi_regs_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int N_EXT_CFG  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [3:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              seq_done,
    input  logic [7:0]        seq_status,
    input  logic [7:0]        seq_intr,
    input  logic [7:0]        seq_step,
    output logic              seq_go,
    output logic [2:0]        seq_op,
    output logic [16:0]       seq_len,
    output logic              dma_mode,
    output logic              irq
);
    localparam int CNT_W    = $clog2(FIFO_DEPTH+1);
    localparam int EXT_BASE = 12;

    logic              acc_wr, acc_rd, wr_cmd, chip_clr, fifo_clr;
    logic              fifo_empty;
    logic [DATA_W-1:0] fifo_head, last_pop;
    logic [CNT_W-1:0]  fifo_count;
    cmd_act_t          act;

    logic [DATA_W-1:0] cnt_lo, cnt_hi, cmd_q, stat_q, intr_q, step_q;
    logic [DATA_W-1:0] cfg_a, cfg_b;
    logic [DATA_W-1:0] cfg_ext [N_EXT_CFG];
    logic              irq_q, dma_q, go_q;
    seq_op_t           op_q;
    logic [LEN_W-1:0]  len_q, len_next;

    assign acc_wr   = bus_sel && bus_wr;
    assign acc_rd   = bus_sel && !bus_wr;
    assign wr_cmd   = acc_wr && (bus_addr == RI_CMD);
    assign chip_clr = wr_cmd && act.chip_rst;
    assign fifo_clr = chip_clr || (wr_cmd && act.flush);
    assign len_next = ({cnt_hi, cnt_lo} == '0) ? LEN_W'(1) << (2*DATA_W)
                                               : LEN_W'({cnt_hi, cnt_lo});

    scsi_cmd_decode u_dec (
        .opcode (bus_wdata[6:0]),
        .act    (act)
    );

    scsi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (fifo_clr),
        .push  (acc_wr && bus_addr == RI_FIFO),
        .pop   (acc_rd && bus_addr == RI_FIFO),
        .wdata (bus_wdata),
        .head  (fifo_head),
        .count (fifo_count),
        .empty (fifo_empty)
    );

    // Extension configuration registers; one slot resets to the ID value
    for (genvar g = 0; g < N_EXT_CFG; g++) begin : g_ext
        localparam logic [DATA_W-1:0] RST_VAL = (g == ID_SLOT) ? ID_VALUE : '0;
        // Store full byte on write, reset value on either reset
        always_ff @(posedge clk) begin
            if (!rst_n || chip_clr)
                cfg_ext[g] <= RST_VAL;
            else if (acc_wr && bus_addr == IDX_W'(EXT_BASE + g))
                cfg_ext[g] <= bus_wdata;
        end
    end

    // Last byte removed from the FIFO, returned on empty reads
    always_ff @(posedge clk) begin
        if (!rst_n || chip_clr)
            last_pop <= '0;
        else if (acc_rd && bus_addr == RI_FIFO && !fifo_empty)
            last_pop <= fifo_head;
    end

    // Main register, interrupt and request state
    always_ff @(posedge clk) begin
        if (!rst_n || chip_clr) begin
            cnt_lo <= '0;  cnt_hi <= '0;  cmd_q  <= '0;
            stat_q <= '0;  intr_q <= '0;  step_q <= '0;
            cfg_a  <= '0;  cfg_b  <= '0;
            irq_q  <= 1'b0; dma_q <= 1'b0; go_q <= 1'b0;
            op_q   <= SEQ_NONE;
            len_q  <= '0;
        end else begin
            go_q <= 1'b0;
            if (seq_done) begin
                stat_q <= seq_status;
                intr_q <= seq_intr;
                step_q <= seq_step;
                irq_q  <= 1'b1;
            end
            if (acc_rd && bus_addr == RI_INTR) begin
                stat_q <= stat_q & STAT_KEEP_MASK;
                irq_q  <= 1'b0;
            end
            if (acc_wr) begin
                case (bus_addr)
                    RI_CNT_LO: cnt_lo <= bus_wdata;
                    RI_CNT_HI: cnt_hi <= bus_wdata;
                    RI_CFG_A:  cfg_a  <= bus_wdata;
                    RI_CFG_B:  cfg_b  <= bus_wdata & CFG_B_MASK;
                    RI_CMD: begin
                        cmd_q <= bus_wdata;
                        dma_q <= bus_wdata[7];
                        if (act.flush) begin
                            intr_q <= INTR_FUNC_DONE;
                            step_q <= '0;
                        end
                        if (act.bus_rst) begin
                            intr_q <= INTR_BUS_RESET;
                            if (!cfg_a[IRQ_MASK_BIT]) irq_q <= 1'b1;
                        end
                        if (act.seq_go) begin
                            go_q  <= 1'b1;
                            op_q  <= act.op;
                            len_q <= len_next;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // Read data selection
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RI_CNT_LO: bus_rdata = cnt_lo;
            RI_CNT_HI: bus_rdata = cnt_hi;
            RI_FIFO:   bus_rdata = fifo_empty ? last_pop : fifo_head;
            RI_CMD:    bus_rdata = cmd_q;
            RI_STAT:   bus_rdata = stat_q;
            RI_INTR:   bus_rdata = intr_q;
            RI_STEP:   bus_rdata = step_q;
            RI_LEVEL:  bus_rdata = DATA_W'(fifo_count);
            RI_CFG_A:  bus_rdata = cfg_a;
            RI_CFG_B:  bus_rdata = cfg_b;
            default: begin
                for (int k = 0; k < N_EXT_CFG; k++)
                    if (bus_addr == IDX_W'(EXT_BASE + k)) bus_rdata = cfg_ext[k];
            end
        endcase
    end

    assign seq_go   = go_q;
    assign seq_op   = op_q;
    assign seq_len  = len_q;
    assign dma_mode = dma_q;
    assign irq      = irq_q;
endmodule

// File: rtl/scsi_ctrl_regs_chk.sv
`timescale 1ns/1ps
// Property checker for scsi_ctrl_regs, attached by bind.
// Observes the host port, sequencer strobe and a few internal registers.
module scsi_ctrl_regs_chk #(
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [3:0]       bus_addr,
    input logic [7:0]       bus_wdata,
    input logic             seq_done,
    input logic             seq_go,
    input logic             dma_mode,
    input logic             irq,
    input logic [7:0]       stat_q,
    input logic [7:0]       cfg_a,
    input logic [CNT_W-1:0] fifo_count
);
    logic cmd_wr, intr_rd, op_known;
    assign cmd_wr  = bus_sel && bus_wr && bus_addr == 4'd3;
    assign intr_rd = bus_sel && !bus_wr && bus_addr == 4'd5;
    assign op_known = bus_wdata[6:0] inside {7'h01, 7'h02, 7'h03, 7'h10,
                                             7'h11, 7'h12, 7'h42, 7'h43};

    // R2
    fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(FIFO_DEPTH));

    // R6
    irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (intr_rd && !seq_done) |=> !irq);

    // R6
    stat_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (intr_rd && !seq_done) |=> ((stat_q & 8'hEF) == 8'h00));

    // R8
    busrst_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && bus_wdata[6:0] == 7'h03 && cfg_a[6] && !irq && !seq_done) |=> !irq);

    // R9
    chip_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && bus_wdata[6:0] == 7'h02) |=> (!irq && !dma_mode && fifo_count == '0));

    // R10
    go_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_go |-> $past(cmd_wr));

    // R12
    unknown_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !op_known && !irq && !seq_done) |=> (!irq && !seq_go));
endmodule

bind scsi_ctrl_regs scsi_ctrl_regs_chk #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .CNT_W      ($clog2(FIFO_DEPTH+1))
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .seq_done   (seq_done),
    .seq_go     (seq_go),
    .dma_mode   (dma_mode),
    .irq        (irq),
    .stat_q     (stat_q),
    .cfg_a      (cfg_a),
    .fifo_count (fifo_count)
);

// File: tb/scsi_ctrl_regs_test.sv
`timescale 1ns/1ps
module scsi_ctrl_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        seq_done = 1'b0;
    logic [7:0]  seq_status = '0, seq_intr = '0, seq_step = '0;
    logic        seq_go, dma_mode, irq;
    logic [2:0]  seq_op;
    logic [16:0] seq_len;

    int n_vec = 0;
    int n_bad = 0;
    int    exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;   // 50 MHz

    scsi_ctrl_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .seq_done(seq_done), .seq_status(seq_status), .seq_intr(seq_intr),
        .seq_step(seq_step), .seq_go(seq_go), .seq_op(seq_op),
        .seq_len(seq_len), .dma_mode(dma_mode), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FIFO-free FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare each read against the scoreboard queue
    always @(negedge clk) begin
        if (bus_sel && !bus_wr) begin
            if (exp_q.size() == 0) begin
                n_vec++; n_bad++;
                $display("FAIL R1: read with no expected item, got 0x%0h expected none", bus_rdata);
            end else begin
                chk(tag_q.pop_front(), int'(bus_rdata), exp_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [3:0] idx, input logic [7:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = idx; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx, input int exp, input string tag);
        @(posedge clk); #1;
        exp_q.push_back(exp); tag_q.push_back(tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = idx;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic report(input logic [7:0] st, input logic [7:0] it, input logic [7:0] sp);
        @(posedge clk); #1;
        seq_done = 1'b1; seq_status = st; seq_intr = it; seq_step = sp;
        @(posedge clk); #1;
        seq_done = 1'b0;
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R9 reset state
        chk("R9 irq after reset", irq, 0);
        chk("R9 dma after reset", dma_mode, 0);
        rd(4'd14, 8'h04, "R9 id value");
        rd(4'd4, 0, "R9 status zero");
        rd(4'd7, 0, "R9 fifo empty");

        // R4 configuration storage
        wr(4'd11, 8'hFF); rd(4'd11, 8'h15, "R4 masked cfg");
        wr(4'd8, 8'hA5);  rd(4'd8, 8'hA5, "R4 cfg8");
        wr(4'd12, 8'h3C); rd(4'd12, 8'h3C, "R4 cfg12");
        wr(4'd15, 8'hC3); rd(4'd15, 8'hC3, "R4 cfg15");
        for (int i = 4; i <= 7; i++) wr(4'(i), 8'hFF);
        wr(4'd9, 8'hFF); wr(4'd10, 8'hFF);
        rd(4'd4, 0, "R4 status ignores write");
        rd(4'd5, 0, "R4 intr ignores write");
        rd(4'd6, 0, "R4 step ignores write");
        rd(4'd7, 0, "R4 level ignores write");
        rd(4'd9, 0, "R4 idx9 zero");
        rd(4'd10, 0, "R4 idx10 zero");
        chk("R4 no irq from writes", irq, 0);

        // R2 / R3 FIFO order, level, empty read
        wr(4'd2, 8'h11); wr(4'd2, 8'h22); wr(4'd2, 8'h33);
        rd(4'd7, 3, "R2 level 3");
        rd(4'd2, 8'h11, "R2 pop1");
        rd(4'd2, 8'h22, "R2 pop2");
        rd(4'd2, 8'h33, "R2 pop3");
        rd(4'd2, 8'h33, "R3 empty pop repeats last");
        rd(4'd7, 0, "R3 level stays 0");
        for (int i = 0; i < 17; i++) wr(4'd2, 8'(8'h40 + i));
        rd(4'd7, 16, "R2 level full");
        for (int i = 0; i < 16; i++) rd(4'd2, 8'h40 + i, "R2 full drain order");
        rd(4'd2, 8'h4F, "R3 overflow byte dropped");
        rd(4'd7, 0, "R2 drained");

        // R10 / R11 / R5 sequencer requests
        wr(4'd0, 8'h00); wr(4'd1, 8'h00); wr(4'd3, 8'h90);
        chk("R10 go xfer", seq_go, 1);
        chk("R10 op xfer", seq_op, 1);
        chk("R11 zero count len", seq_len, 17'h10000);
        chk("R5 dma on", dma_mode, 1);
        @(posedge clk); #1;
        chk("R10 go one cycle", seq_go, 0);
        wr(4'd0, 8'h34); wr(4'd1, 8'h12); wr(4'd3, 8'h42);
        chk("R10 go sel", seq_go, 1);
        chk("R10 op sel", seq_op, 2);
        chk("R10 len", seq_len, 17'h01234);
        chk("R5 dma off", dma_mode, 0);
        rd(4'd3, 8'h42, "R5 cmd readback");
        wr(4'd3, 8'h43); chk("R10 op sel stop", seq_op, 3);
        wr(4'd3, 8'h11); chk("R10 op cmpl", seq_op, 4);
        wr(4'd3, 8'h12); chk("R10 op msgacc", seq_op, 5);
        chk("R10 no irq from request", irq, 0);

        // R12 unknown opcode and NOP
        wr(4'd3, 8'hFF);
        chk("R12 unknown no go", seq_go, 0);
        chk("R12 unknown no irq", irq, 0);
        chk("R5 dma from unknown", dma_mode, 1);
        wr(4'd3, 8'h00);
        chk("R12 nop no go", seq_go, 0);
        rd(4'd5, 0, "R12 intr unchanged");
        rd(4'd6, 0, "R12 step unchanged");

        // R6 sequencer report and acknowledge
        report(8'h91, 8'h18, 8'h04);
        chk("R6 irq raised", irq, 1);
        rd(4'd4, 8'h91, "R6 status loaded");
        rd(4'd6, 8'h04, "R6 step loaded");
        rd(4'd5, 8'h18, "R6 intr code");
        chk("R6 irq dropped", irq, 0);
        rd(4'd4, 8'h10, "R6 status keeps tc");

        // R7 flush
        wr(4'd2, 8'hAA); wr(4'd2, 8'hBB);
        wr(4'd3, 8'h01);
        chk("R7 irq unchanged", irq, 0);
        rd(4'd5, 8'h08, "R7 intr func done");
        rd(4'd6, 0, "R7 step cleared");
        rd(4'd7, 0, "R7 fifo emptied");

        // R8 bus reset, masked then unmasked
        wr(4'd8, 8'h40); wr(4'd3, 8'h03);
        chk("R8 masked no irq", irq, 0);
        rd(4'd5, 8'h80, "R8 intr bus reset");
        wr(4'd8, 8'h00); wr(4'd3, 8'h03);
        chk("R8 unmasked irq", irq, 1);

        // R9 chip reset with state present
        wr(4'd12, 8'h3C); wr(4'd14, 8'h99); wr(4'd0, 8'h55); wr(4'd8, 8'h21);
        rd(4'd14, 8'h99, "R4 id slot writable");
        wr(4'd2, 8'h77);
        wr(4'd3, 8'h82);
        chk("R9 irq cleared", irq, 0);
        chk("R9 dma cleared", dma_mode, 0);
        rd(4'd0, 0, "R9 count cleared");
        rd(4'd8, 0, "R9 cfg8 cleared");
        rd(4'd12, 0, "R9 cfg12 cleared");
        rd(4'd14, 8'h04, "R9 id restored");
        rd(4'd7, 0, "R9 fifo cleared");
        rd(4'd3, 0, "R9 cmd cleared");
        rd(4'd5, 0, "R9 intr cleared");

        @(posedge clk); #1;
        finish_run();
    end
endmodule